// File: doc/BRIEF.md
# Quadrature Sine/Cosine Lookup

This block turns a phase word into a matched sine and cosine pair. It holds a single table covering one full waveform period in a two-read-port synchronous memory. One port reads the table at the phase itself and gives the sine. The other port reads at the phase advanced by a quarter period, which gives the cosine. Both reads are issued together, so the pair leaves the block in the same cycle.

The table contents are computed by a package function while the design is elaborated. Entry `n` holds the rounded value of full scale times sin(2πn/DEPTH). A caller presents a phase with a strobe. One clock later it receives both samples with a matching valid flag. A new phase may be presented every cycle.

Top module: `quad_sincos_lut`

## Requirements
- R1: One clock after a cycle with `phase_valid` high, `sin_out` equals round(32767·sin(2π·p/256)) in two's complement, where p is the 8-bit phase presented in that cycle.
- R2: In the same cycle, `cos_out` equals the table entry at address (p + 64) mod 256. For every p this equals the `sin_out` produced for phase (p + 64) mod 256.
- R3: `out_valid` is `phase_valid` delayed by exactly one clock.
- R4: In a cycle with `phase_valid` low, the phase input has no effect. On the next clock, `sin_out` and `cos_out` keep their previous values.
- R5: While `rst` is high, `out_valid`, `sin_out` and `cos_out` are all zero after the clock edge.
- R6: The cosine address wraps modulo 256. Phase 255 gives the cosine of entry 63, and phase 192 gives the cosine of entry 0.
- R7: Whenever `out_valid` is high, sin²+cos² lies within 65536 of 32767².
- R8: Phases presented on consecutive cycles produce results on consecutive cycles, each belonging to its own phase.
- R9: The key points are exact. Phase 0 gives (0, 32767), phase 64 gives (32767, 0), phase 128 gives (0, −32767) and phase 192 gives (−32767, 0). No output ever equals −32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| phase_valid | input | 1 | Strobe qualifying `phase` |
| phase | input | 8 | Phase word, one full period spans 256 steps |
| sin_out | output | 16 | Signed sine sample |
| cos_out | output | 16 | Signed cosine sample |
| out_valid | output | 1 | High when the sample pair belongs to the phase strobed one clock earlier |

## Verification
Each of the block's results is due exactly one rising edge after its phase is strobed: the sine, the cosine and the valid flag all come through one register stage. The bench changes inputs on falling edges. It reads the outputs on the next falling edge, half a period after the edge that loaded them, and only then applies the next phase, so a streaming sweep checks every result in its own slot. Held values after an idle strobe are read on each following falling edge. The cross-check of cosine against the sine a quarter period ahead uses the samples collected in the sweep, so it rests on results already taken at the correct cycle.

// File: rtl/qsc_pkg.sv
package qsc_pkg;

    // Default geometry of the waveform table
    localparam int PHASE_W    = 8;
    localparam int AMP_W      = 16;
    localparam int DEPTH      = 1 << PHASE_W;
    localparam int FULL_SCALE = (1 << (AMP_W - 1)) - 1;

    localparam real TWO_PI = 6.28318530717958647692;

    // Rounded sample of one full sine period, evaluated at elaboration
    function automatic int wave_entry(input int n, input int depth, input int scale);
        real ang;
        real v;
        ang = TWO_PI * real'(n) / real'(depth);
        v   = real'(scale) * $sin(ang);
        if (v >= 0.0)
            return $rtoi($floor(v + 0.5));
        else
            return -$rtoi($floor(-v + 0.5));
    endfunction

    // Address offset that corresponds to a quarter of the period
    function automatic int quarter_offset(input int depth);
        return depth / 4;
    endfunction

endpackage

// File: rtl/qsc_addr_gen.sv
module qsc_addr_gen
    import qsc_pkg::*;
#(
    parameter int PW = qsc_pkg::PHASE_W
) (
    input  logic [PW-1:0] phase,
    output logic [PW-1:0] sin_addr,
    output logic [PW-1:0] cos_addr
);
    localparam int TBL_DEPTH = 1 << PW;
    localparam logic [PW-1:0] QTR = PW'(quarter_offset(TBL_DEPTH));

    typedef struct packed {
        logic [PW-1:0] s_addr;
        logic [PW-1:0] c_addr;
    } addr_pair_t;

    addr_pair_t pair;

    // The sum is truncated to PW bits, so it wraps modulo the table depth
    always_comb begin
        pair.s_addr = phase;
        pair.c_addr = phase + QTR;
    end

    assign sin_addr = pair.s_addr;
    assign cos_addr = pair.c_addr;

endmodule

// File: rtl/qsc_dual_rom.sv
module qsc_dual_rom
    import qsc_pkg::*;
#(
    parameter int AW = qsc_pkg::PHASE_W,
    parameter int DW = qsc_pkg::AMP_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_en,
    input  logic [AW-1:0]        addr_a,
    input  logic [AW-1:0]        addr_b,
    output logic signed [DW-1:0] q_a,
    output logic signed [DW-1:0] q_b
);
    localparam int WORDS = 1 << AW;
    localparam int SCALE = (1 << (DW - 1)) - 1;

    logic signed [DW-1:0] table_mem [WORDS];

    // Fill every word from the package function; no file is read
    for (genvar i = 0; i < WORDS; i++) begin : g_fill
        localparam logic signed [DW-1:0] ENTRY = DW'(wave_entry(i, WORDS, SCALE));
        assign table_mem[i] = ENTRY;
    end

    // Two independent synchronous read ports over the same storage
    always_ff @(posedge clk) begin
        if (rst) begin
            q_a <= '0;
            q_b <= '0;
        end else if (rd_en) begin
            q_a <= table_mem[addr_a];
            q_b <= table_mem[addr_b];
        end
    end

endmodule

// File: rtl/qsc_valid_pipe.sv
module qsc_valid_pipe #(
    parameter int STAGES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic out_valid
);
    logic [STAGES-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst)
            stage_q <= '0;
        else
            stage_q <= {stage_q, in_valid};
    end

    assign out_valid = stage_q[STAGES-1];

endmodule

// File: rtl/quad_sincos_lut.sv
module quad_sincos_lut
    import qsc_pkg::*;
#(
    parameter int PHASE_BITS = qsc_pkg::PHASE_W,
    parameter int AMP_BITS   = qsc_pkg::AMP_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       phase_valid,
    input  logic [PHASE_BITS-1:0]      phase,
    output logic signed [AMP_BITS-1:0] sin_out,
    output logic signed [AMP_BITS-1:0] cos_out,
    output logic                       out_valid
);
    localparam int READ_LATENCY = 1;

    typedef struct packed {
        logic signed [AMP_BITS-1:0] s_val;
        logic signed [AMP_BITS-1:0] c_val;
    } wave_pair_t;

    logic [PHASE_BITS-1:0] sin_addr;
    logic [PHASE_BITS-1:0] cos_addr;
    wave_pair_t            rd_pair;

    qsc_addr_gen #(
        .PW (PHASE_BITS)
    ) u_addr (
        .phase    (phase),
        .sin_addr (sin_addr),
        .cos_addr (cos_addr)
    );

    qsc_dual_rom #(
        .AW (PHASE_BITS),
        .DW (AMP_BITS)
    ) u_rom (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (phase_valid),
        .addr_a (sin_addr),
        .addr_b (cos_addr),
        .q_a    (rd_pair.s_val),
        .q_b    (rd_pair.c_val)
    );

    qsc_valid_pipe #(
        .STAGES (READ_LATENCY)
    ) u_vld (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (phase_valid),
        .out_valid (out_valid)
    );

    assign sin_out = rd_pair.s_val;
    assign cos_out = rd_pair.c_val;

endmodule

// File: rtl/qsc_chk.sv
module qsc_chk #(
    parameter int AMP_BITS = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       phase_valid,
    input logic signed [AMP_BITS-1:0] sin_out,
    input logic signed [AMP_BITS-1:0] cos_out,
    input logic                       out_valid
);
    localparam longint FS     = (64'sd1 <<< (AMP_BITS - 1)) - 1;
    localparam longint FS_SQ  = FS * FS;
    localparam longint TOL    = 65536;
    localparam logic signed [AMP_BITS-1:0] MOST_NEG = {1'b1, {(AMP_BITS-1){1'b0}}};

    longint energy;
    always_comb energy = longint'(sin_out) * longint'(sin_out)
                       + longint'(cos_out) * longint'(cos_out);

    // R3
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        phase_valid |=> out_valid);

    // R3
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !phase_valid |=> !out_valid);

    // R4
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !phase_valid |=> ($stable(sin_out) && $stable(cos_out)));

    // R7
    unit_circle_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (energy >= FS_SQ - TOL && energy <= FS_SQ + TOL));

    // R9
    no_most_neg_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (sin_out != MOST_NEG && cos_out != MOST_NEG));

endmodule

bind quad_sincos_lut qsc_chk #(.AMP_BITS(AMP_BITS)) u_qsc_chk (
    .clk         (clk),
    .rst         (rst),
    .phase_valid (phase_valid),
    .sin_out     (sin_out),
    .cos_out     (cos_out),
    .out_valid   (out_valid)
);

// File: tb/quad_sincos_lut_test.sv
`timescale 1ns/1ps
module quad_sincos_lut_test;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               phase_valid = 1'b0;
    logic [7:0]         phase = '0;
    logic signed [15:0] sin_out;
    logic signed [15:0] cos_out;
    logic               out_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic signed [15:0] sin_seen [256];
    logic signed [15:0] cos_seen [256];

    always #2.5 clk = ~clk;

    quad_sincos_lut uut (
        .clk         (clk),
        .rst         (rst),
        .phase_valid (phase_valid),
        .phase       (phase),
        .sin_out     (sin_out),
        .cos_out     (cos_out),
        .out_valid   (out_valid)
    );

    function automatic longint expect_sin(input int n);
        real v;
        v = 32767.0 * $sin(6.28318530717958647692 * real'(n % 256) / 256.0);
        if (v >= 0.0) return longint'($rtoi($floor(v + 0.5)));
        else          return -longint'($rtoi($floor(-v + 0.5)));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_pair(input string req, input int p);
        check(sin_out == 16'(expect_sin(p)), req, $sformatf("sine p=%0d", p),
              longint'(sin_out), expect_sin(p));
        check(cos_out == 16'(expect_sin(p + 64)), req, $sformatf("cosine p=%0d", p),
              longint'(cos_out), expect_sin(p + 64));
    endtask

    // R5: outputs cleared under reset
    task automatic test_reset();
        rst = 1'b1;
        phase_valid = 1'b1;
        phase = 8'd64;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R5", "out_valid in reset", longint'(out_valid), 0);
        check(sin_out == 0, "R5", "sin_out in reset", longint'(sin_out), 0);
        check(cos_out == 0, "R5", "cos_out in reset", longint'(cos_out), 0);
        phase_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    // R1 R2 R3 R7 R8: back-to-back sweep of every phase
    task automatic test_sweep();
        for (int p = 0; p < 256; p++) begin
            phase_valid = 1'b1;
            phase = 8'(p);
            @(negedge clk);
            check_pair("R1/R8", p);
            check(out_valid == 1'b1, "R3", $sformatf("valid after p=%0d", p),
                  longint'(out_valid), 1);
            begin
                longint e = longint'(sin_out) * sin_out + longint'(cos_out) * cos_out;
                longint d = e - 64'sd1073676289;
                if (d < 0) d = -d;
                check(d <= 65536, "R7", $sformatf("energy p=%0d", p), e, 1073676289);
            end
            sin_seen[p] = sin_out;
            cos_seen[p] = cos_out;
        end
        phase_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R3", "valid drops after sweep", longint'(out_valid), 0);
        for (int p = 0; p < 256; p++) begin
            check(cos_seen[p] == sin_seen[(p + 64) % 256], "R2",
                  $sformatf("cos(p=%0d) vs sin(p+64)", p),
                  longint'(cos_seen[p]), longint'(sin_seen[(p + 64) % 256]));
        end
        // R6: wrap of the cosine address
        check(cos_seen[255] == sin_seen[63], "R6", "cos at 255 vs entry 63",
              longint'(cos_seen[255]), longint'(sin_seen[63]));
        check(cos_seen[192] == sin_seen[0], "R6", "cos at 192 vs entry 0",
              longint'(cos_seen[192]), longint'(sin_seen[0]));
    endtask

    // R4: idle cycles do not change outputs
    task automatic test_hold();
        phase_valid = 1'b1;
        phase = 8'd32;
        @(negedge clk);
        check_pair("R1", 32);
        phase_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            phase = 8'(100 + 40 * k);
            @(negedge clk);
            check_pair("R4", 32);
            check(out_valid == 1'b0, "R4", "valid low while idle", longint'(out_valid), 0);
        end
    endtask

    // R9: exact key points
    task automatic test_keypoints();
        int pts [4] = '{0, 64, 128, 192};
        int es  [4] = '{0, 32767, 0, -32767};
        int ec  [4] = '{32767, 0, -32767, 0};
        for (int k = 0; k < 4; k++) begin
            phase_valid = 1'b1;
            phase = 8'(pts[k]);
            @(negedge clk);
            check(sin_out == 16'(es[k]), "R9", $sformatf("sine key %0d", pts[k]),
                  longint'(sin_out), longint'(es[k]));
            check(cos_out == 16'(ec[k]), "R9", $sformatf("cosine key %0d", pts[k]),
                  longint'(cos_out), longint'(ec[k]));
        end
        phase_valid = 1'b0;
        @(negedge clk);
    endtask

    // R3 R8: gapped strobes
    task automatic test_gaps();
        int ph  [6] = '{10, 0, 200, 0, 255, 7};
        bit vld [6] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
        int last = 0;
        for (int k = 0; k < 6; k++) begin
            phase_valid = vld[k];
            phase = 8'(vld[k] ? ph[k] : 77);
            @(negedge clk);
            check(out_valid == vld[k], "R3", $sformatf("gap step %0d", k),
                  longint'(out_valid), longint'(vld[k]));
            if (vld[k]) last = ph[k];
            check_pair("R8", last);
        end
        phase_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        test_reset();
        test_sweep();
        test_hold();
        test_keypoints();
        test_gaps();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule